// File: doc/BRIEF.md
# DRAM Row/Column Access Sequencer

This block runs a single DRAM access. It puts the row half of the processor address on the memory address bus and drops RAS. It holds the row for a programmed number of clocks, then switches the bus to the column half. After a programmed setup interval it drops CAS. Both strobes stay low until the processor withdraws its access request. Then a fixed precharge interval runs before the next access may start.

An access can be launched in two ways:

- **Synchronous mode.** A single-clock pulse on the latch strobe, qualified by chip select, is captured in an internal flag together with the address. RAS follows on the next clock edge.
- **Asynchronous mode.** RAS follows the address strobe combinationally, without waiting for a clock edge. The next clock edge registers the access.

A busy output tells an outside arbiter when the memory is taken. All pins are plain control levels; there is no streaming handshake.

Top module: `dram_seq`

## Requirements
- R1: In synchronous mode (`mode_async`=0), a clock edge that samples `ale` and `chip_sel` both high while the block is idle and unarmed captures the start and the address. `ras_n` stays high after that edge and goes low after the following edge. `ale` may drop after the capturing edge.
- R2: From the edge that asserts RAS, for `row_hold` clocks, `mem_addr` carries the row field `addr[ROW_W+COL_W-1:COL_W]` of the captured address and `cas_n` stays high.
- R3: After the row phase, `mem_addr` carries the column field `addr[COL_W-1:0]` (zero-extended) for `col_setup` clocks with `cas_n` high. Then `cas_n` goes low, and it only ever goes low while `ras_n` is already low.
- R4: A programmed `row_hold` or `col_setup` value of 0 behaves as 1 clock.
- R5: Once CAS is low, RAS and CAS stay low for as long as `areq` has not yet been seen high during the access, and for as long as `areq` remains high.
- R6: The first edge in the CAS phase that samples `areq` low, after `areq` has been seen high since RAS asserted, raises `ras_n` and `cas_n` on the same edge. `mem_addr` then returns to the row field.
- R7: After the end of an access, `ras_n` and `cas_n` stay high for PRE_CYC (default 2) clocks with `busy` high. `busy` falls after that interval.
- R8: In asynchronous mode (`mode_async`=1), while idle, `ads` with `chip_sel` high drives `ras_n` low and `busy` high at once, with no clock edge, and `mem_addr` shows the row field of the live `cpu_addr`. The next edge registers the access and latches the address, after which `ads` may drop.
- R9: `ale` or `ads` without `chip_sel` starts nothing. `ale`/`chip_sel` held during an access or its precharge starts nothing.
- R10: `busy` is high whenever `ras_n` is low.
- R11: After reset, `ras_n` and `cas_n` are high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_async | input | 1 | 0: start from captured `ale` pulse; 1: start from `ads` |
| chip_sel | input | 1 | Qualifies `ale` and `ads` |
| ale | input | 1 | Synchronous start / address latch pulse |
| ads | input | 1 | Asynchronous start strobe |
| areq | input | 1 | Access request; its release ends the access |
| row_hold | input | HOLD_W | Row-hold clocks after RAS (0 treated as 1) |
| col_setup | input | HOLD_W | Column setup clocks before CAS (0 treated as 1) |
| cpu_addr | input | ROW_W+COL_W | Processor address, row in the upper field |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed memory address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| busy | output | 1 | Memory in use, from RAS through precharge |

## Verification
The checks assume that `row_hold`, `col_setup` and `mode_async` stay constant for the duration of an access. They also assume that `ads` is held only until the edge that registers an asynchronous start. The stimulus changes every control input one nanosecond after a rising edge and reprograms the counts only between accesses, while the block is idle. `ads` is dropped right after the registering edge, and the start pulses stay one clock wide except where a test deliberately holds them across precharge.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_ACT  = 3'd3,
    ST_PRE  = 3'd4
  } seq_state_t;

  // Programmed interval with a floor of one clock, returned as count-1.
  function automatic logic [7:0] span_minus1(input logic [7:0] prog);
    return (prog == 8'd0) ? 8'd0 : prog - 8'd1;
  endfunction

endpackage

// File: rtl/dram_seq_start.sv
module dram_seq_start #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          mode_async,
  input  logic          chip_sel,
  input  logic          ale,
  input  logic          ads,
  input  logic [AW-1:0] cpu_addr,
  output logic          launch,
  output logic          async_go,
  output logic [AW-1:0] addr_eff
);

  logic          armed_q;
  logic [AW-1:0] addr_q;
  logic          arm_set;

  assign arm_set  = idle & ~armed_q & ~mode_async & ale & chip_sel;
  assign async_go = idle & ~armed_q & mode_async & ads & chip_sel;
  assign launch   = idle & (armed_q | async_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (launch)       armed_q <= 1'b0;
      else if (arm_set) armed_q <= 1'b1;
      if (arm_set || async_go) addr_q <= cpu_addr;
    end
  end

  // While idle and unarmed the live address is shown (asynchronous start).
  assign addr_eff = (idle && !armed_q) ? cpu_addr : addr_q;

endmodule

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/dram_seq_amux.sv
module dram_seq_amux #(
  parameter int ROW_W = 10,
  parameter int COL_W = 8,
  localparam int AW   = ROW_W + COL_W,
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic [AW-1:0]   addr,
  input  logic            col_phase,
  output logic [MA_W-1:0] mem_addr
);

  logic [MA_W-1:0] row_f;
  logic [MA_W-1:0] col_f;

  generate
    if (ROW_W == MA_W) begin : g_row_full
      assign row_f = addr[AW-1:COL_W];
    end else begin : g_row_pad
      assign row_f = {{(MA_W-ROW_W){1'b0}}, addr[AW-1:COL_W]};
    end
    if (COL_W == MA_W) begin : g_col_full
      assign col_f = addr[COL_W-1:0];
    end else begin : g_col_pad
      assign col_f = {{(MA_W-COL_W){1'b0}}, addr[COL_W-1:0]};
    end
  endgenerate

  assign mem_addr = col_phase ? col_f : row_f;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 8,
  parameter int HOLD_W  = 2,
  parameter int PRE_CYC = 2,
  localparam int AW     = ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int PRE_W  = (PRE_CYC > 2) ? $clog2(PRE_CYC) : 1,
  localparam int CW     = (HOLD_W > PRE_W) ? HOLD_W : PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_async,
  input  logic              chip_sel,
  input  logic              ale,
  input  logic              ads,
  input  logic              areq,
  input  logic [HOLD_W-1:0] row_hold,
  input  logic [HOLD_W-1:0] col_setup,
  input  logic [AW-1:0]     cpu_addr,
  output logic [MA_W-1:0]   mem_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              busy
);

  seq_state_t    state_q, state_d;
  logic          seen_q;
  logic          launch, async_go;
  logic [AW-1:0] addr_eff;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic [7:0]    rh_m1, cs_m1;

  assign rh_m1 = span_minus1(8'(row_hold));
  assign cs_m1 = span_minus1(8'(col_setup));

  dram_seq_start #(.AW(AW)) u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (state_q == ST_IDLE),
    .mode_async (mode_async),
    .chip_sel   (chip_sel),
    .ale        (ale),
    .ads        (ads),
    .cpu_addr   (cpu_addr),
    .launch     (launch),
    .async_go   (async_go),
    .addr_eff   (addr_eff)
  );

  dram_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  dram_seq_amux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
    .addr      (addr_eff),
    .col_phase ((state_q == ST_COL) || (state_q == ST_ACT)),
    .mem_addr  (mem_addr)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (launch) begin
        state_d  = ST_ROW;
        tmr_load = 1'b1;
        tmr_val  = CW'(rh_m1);
      end
      ST_ROW: if (tmr_done) begin
        state_d  = ST_COL;
        tmr_load = 1'b1;
        tmr_val  = CW'(cs_m1);
      end
      ST_COL: if (tmr_done) state_d = ST_ACT;
      ST_ACT: if (seen_q && !areq) begin
        state_d  = ST_PRE;
        tmr_load = 1'b1;
        tmr_val  = CW'(PRE_CYC - 1);
      end
      ST_PRE: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE || state_q == ST_PRE) seen_q <= 1'b0;
      else if (areq)                               seen_q <= 1'b1;
    end
  end

  assign ras_n = ~((state_q == ST_ROW) || (state_q == ST_COL) ||
                   (state_q == ST_ACT) || async_go);
  assign cas_n = ~(state_q == ST_ACT);
  assign busy  = (state_q != ST_IDLE) || async_go;

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic busy,
  input logic areq
);

  a_r10_busy_covers_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> busy);

  a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  a_r3_cas_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(!ras_n));

  a_r5_cas_held_by_areq: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && areq) |=> !cas_n);

  a_r6_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n));

  a_r7_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> (ras_n && busy));

endmodule

bind dram_seq dram_seq_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ras_n (ras_n),
  .cas_n (cas_n),
  .busy  (busy),
  .areq  (areq)
);

// File: tb/tb_dram_seq.sv
module tb_dram_seq;

  localparam int ROW_W = 10;
  localparam int COL_W = 8;
  localparam int AW    = ROW_W + COL_W;
  localparam int MA_W  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_async = 1'b0;
  logic          chip_sel = 1'b0;
  logic          ale = 1'b0;
  logic          ads = 1'b0;
  logic          areq = 1'b0;
  logic [1:0]    row_hold = 2'd1;
  logic [1:0]    col_setup = 2'd1;
  logic [AW-1:0] cpu_addr = '0;
  logic [MA_W-1:0] mem_addr;
  logic          ras_n, cas_n, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dram_seq dut (
    .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .chip_sel(chip_sel),
    .ale(ale), .ads(ads), .areq(areq), .row_hold(row_hold),
    .col_setup(col_setup), .cpu_addr(cpu_addr), .mem_addr(mem_addr),
    .ras_n(ras_n), .cas_n(cas_n), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int row_of(input logic [AW-1:0] a);
    return int'(a[AW-1:COL_W]);
  endfunction

  function automatic int col_of(input logic [AW-1:0] a);
    return int'(a[COL_W-1:0]);
  endfunction

  task automatic do_access(input bit am, input logic [1:0] h, input logic [1:0] s,
                           input logic [AW-1:0] a, input bit early, input int waitc,
                           input bit poke);
    int he, se;
    he = (h == 0) ? 1 : int'(h);
    se = (s == 0) ? 1 : int'(s);
    row_hold = h; col_setup = s; mode_async = am; cpu_addr = a;
    if (am) begin
      chip_sel = 1; ads = 1;
      #1;
      chk(ras_n == 0, "R8 ras before edge", ras_n, 0);
      chk(busy == 1, "R8 busy before edge", busy, 1);
      chk(int'(mem_addr) == row_of(a), "R8 live row", mem_addr, row_of(a));
      tick();
      ads = 0; chip_sel = 0; cpu_addr = ~a;
    end else begin
      chip_sel = 1; ale = 1;
      tick();
      ale = 0; chip_sel = 0; cpu_addr = ~a;
      chk(ras_n == 1, "R1 ras after capture edge", ras_n, 1);
      tick();
    end
    if (early) areq = 1;
    for (int i = 0; i < he; i++) begin
      chk(ras_n == 0, "R2 ras low", ras_n, 0);
      chk(cas_n == 1, "R2 cas high", cas_n, 1);
      chk(int'(mem_addr) == row_of(a), "R2 row addr", mem_addr, row_of(a));
      chk(busy == 1, "R10 busy", busy, 1);
      tick();
    end
    for (int i = 0; i < se; i++) begin
      chk(int'(mem_addr) == col_of(a), "R3 col addr", mem_addr, col_of(a));
      chk(cas_n == 1, "R3 cas high in setup", cas_n, 1);
      chk(ras_n == 0, "R3 ras low", ras_n, 0);
      tick();
    end
    chk(cas_n == 0, "R3 cas asserted", cas_n, 0);
    chk(int'(mem_addr) == col_of(a), "R3 col on cas", mem_addr, col_of(a));
    for (int i = 0; i < waitc; i++) begin
      tick();
      chk(!cas_n && !ras_n, "R5 strobes held", {ras_n, cas_n}, 0);
    end
    if (!early) begin
      areq = 1;
      tick();
      chk(!cas_n && !ras_n, "R5 held with areq", {ras_n, cas_n}, 0);
    end
    areq = 0;
    if (poke) begin ale = 1; chip_sel = 1; mode_async = 0; end
    tick();
    chk(ras_n && cas_n, "R6 release", {ras_n, cas_n}, 3);
    chk(int'(mem_addr) == row_of(a), "R6 row back", mem_addr, row_of(a));
    chk(busy == 1, "R7 busy in precharge", busy, 1);
    tick();
    chk(ras_n && cas_n, "R7 precharge strobes", {ras_n, cas_n}, 3);
    chk(busy == 1, "R7 busy precharge 2", busy, 1);
    tick();
    chk(busy == 0, "R7 busy drops", busy, 0);
    if (poke) begin
      ale = 0; chip_sel = 0;
      for (int i = 0; i < 3; i++) begin
        tick();
        chk(ras_n == 1 && busy == 0, "R9 start during busy ignored", ras_n, 1);
      end
    end
  endtask

  task automatic t_reset();
    chk(ras_n == 1, "R11 ras reset", ras_n, 1);
    chk(cas_n == 1, "R11 cas reset", cas_n, 1);
    chk(busy == 0, "R11 busy reset", busy, 0);
  endtask

  task automatic t_no_cs();
    mode_async = 0; chip_sel = 0; ale = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(ras_n == 1 && busy == 0, "R9 ale without cs", ras_n, 1);
    end
    ale = 0;
    mode_async = 1; ads = 1;
    #1;
    chk(ras_n == 1 && busy == 0, "R9 ads without cs", ras_n, 1);
    tick();
    tick();
    chk(ras_n == 1, "R9 ads without cs later", ras_n, 1);
    ads = 0; mode_async = 0;
    tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    do_access(0, 2'd2, 2'd1, 18'h2A5C3, 0, 0, 0);
    do_access(0, 2'd3, 2'd3, 18'h15A3C, 0, 3, 0);
    do_access(0, 2'd0, 2'd0, 18'h3FF01, 0, 1, 0);   // R4 zero counts
    do_access(1, 2'd1, 2'd2, 18'h0C0FF, 0, 2, 0);
    do_access(1, 2'd0, 2'd3, 18'h23456, 1, 0, 0);   // R4, R5 early request
    do_access(0, 2'd2, 2'd2, 18'h1B2D4, 1, 4, 1);   // R9 start held during busy
    t_no_cs();
    do_access(0, 2'd1, 2'd1, 18'h00001, 0, 0, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule